// File: doc/BRIEF.md
# Interrupt Sense Normalizer

This block sits between a bank of raw interrupt wires and a downstream interrupt controller that only accepts two kinds of request: a rising edge or an active-high level. Each input line is given one of five sense types. A line that is active-low is turned into an active-high level. A line that signals on a falling edge, or on either edge, is turned into a one-cycle rising pulse. Lines that are already rising-edge or active-high pass through with the same timing as the converted ones.

Software programs the block through a small word-addressed register port. A packed enable bank holds one bit per line. A separate array holds one 3-bit sense code per line. To change one line's enable, software reads the enable word, alters one bit and writes the word back. Every raw input passes through a two-flop synchronizer and a history flop before detection. The result leaves through a registered gate, so a change on an input shows at the output on the third rising clock edge after it.

Inside each line, the configured code is decoded into a mode: OFF, HIGH, LOW, UP, DOWN or ANY. The mode selects how the synchronized sample and its history bit form the output. There is no sequencing state, so there are no transitions between modes other than a register write.

Top module: `isnc_top`

## Requirements
- R1: After reset every enable bit and every sense code is zero, every output is low, and every register reads zero.
- R2: Enable word w sits at byte address 0x10 + 4*w and holds line n at word n/32, bit n%32. A write replaces that word. A read returns it. Bits for lines at or above NUM_LINES read zero and cannot be set, and a write to one word leaves the other words unchanged.
- R3: The sense code of line n sits in bits [2:0] of byte address 0x110 + 4*n and reads back as written, with bits [31:3] reading zero. Writes to line indices at or above NUM_LINES are ignored and read zero, as do all unmapped addresses.
- R4: Code 100 (active-high level): an enabled line's output equals its synchronized input. An input change shows at the output on the third rising clock edge after it.
- R5: Code 000 (active-low level): an enabled line's output is the inverse of its synchronized input, with the same latency as R4.
- R6: Code 110 (rising edge): an enabled line gives a one-cycle high pulse for each 0-to-1 input transition and stays low otherwise.
- R7: Code 010 (falling edge): an enabled line gives a one-cycle high pulse for each 1-to-0 input transition and stays low otherwise.
- R8: Code 111 (both edges): an enabled line gives a one-cycle high pulse for every input transition.
- R9: A line whose enable bit is clear drives its output low from the clock edge after the clear, whatever its input and code.
- R10: Codes 001, 011 and 101 hold the line's output low.
- R11: Rewriting an enabled line's sense code while its input is steady produces no output pulse.
- R12: The input, enable and code of one line never affect the output of another line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_LINES | Raw interrupt lines, asynchronous |
| irq_out | output | NUM_LINES | Normalized requests to the downstream controller |
| reg_addr | input | 12 | Byte address for register read and write |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
A wrong synchronizer or history bit shows as a missing, doubled or misplaced pulse exactly three clock edges after an input transition. The bench therefore samples each line at that edge and one cycle later, for every sense code. A corrupted enable or code register is visible at once on reg_rdata. It also shows at the line's output within one clock edge, as a level that ignores the input or as a pulse from a disabled line. A line that leaks into another is caught because every output check compares the whole output vector.

// File: rtl/isnc_pkg.sv
package isnc_pkg;

    localparam int MAX_LINES = 126;
    localparam int ADDR_W    = 12;

    localparam logic [ADDR_W-1:0] EN_BASE  = 12'h010;
    localparam logic [ADDR_W-1:0] CFG_BASE = 12'h110;

    // Sense codes as stored in the configuration array
    typedef enum logic [2:0] {
        SENSE_LVL_LO = 3'b000,
        SENSE_FALL   = 3'b010,
        SENSE_LVL_HI = 3'b100,
        SENSE_RISE   = 3'b110,
        SENSE_BOTH   = 3'b111
    } sense_code_e;

    // Per-line conversion mode after decoding
    typedef enum logic [2:0] {
        MODE_OFF,
        MODE_HIGH,
        MODE_LOW,
        MODE_UP,
        MODE_DOWN,
        MODE_ANY
    } line_mode_e;

    function automatic line_mode_e decode_sense(input logic [2:0] code);
        line_mode_e m;
        unique case (code)
            SENSE_LVL_LO: m = MODE_LOW;
            SENSE_FALL:   m = MODE_DOWN;
            SENSE_LVL_HI: m = MODE_HIGH;
            SENSE_RISE:   m = MODE_UP;
            SENSE_BOTH:   m = MODE_ANY;
            default:      m = MODE_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/isnc_regs.sv
module isnc_regs
    import isnc_pkg::*;
#(
    parameter int NUM_LINES = MAX_LINES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_wr,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output logic [NUM_LINES-1:0]      line_en,
    output logic [NUM_LINES-1:0][2:0] line_cfg
);

    localparam int EN_WORDS = (NUM_LINES + 31) / 32;
    localparam int PAD_W    = EN_WORDS * 32;

    logic [PAD_W-1:0] en_pad;

    // One enable flop and one code register per line; nothing exists for
    // indices at or above NUM_LINES, so writes there fall away.
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        localparam logic [ADDR_W-1:0] EN_ADDR = EN_BASE  + ADDR_W'(4 * (n / 32));
        localparam logic [ADDR_W-1:0] CF_ADDR = CFG_BASE + ADDR_W'(4 * n);
        localparam int                BIT_POS = n % 32;

        logic       en_r;
        logic [2:0] cfg_r;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_r  <= 1'b0;
                cfg_r <= 3'b000;
            end else if (reg_wr) begin
                if (reg_addr == EN_ADDR) en_r  <= reg_wdata[BIT_POS];
                if (reg_addr == CF_ADDR) cfg_r <= reg_wdata[2:0];
            end
        end

        assign line_en[n]  = en_r;
        assign line_cfg[n] = cfg_r;
    end

    assign en_pad = PAD_W'(line_en);

    always_comb begin
        reg_rdata = '0;
        for (int w = 0; w < EN_WORDS; w++) begin
            if (reg_addr == EN_BASE + ADDR_W'(4 * w)) begin
                reg_rdata = en_pad[w*32 +: 32];
            end
        end
        for (int n = 0; n < NUM_LINES; n++) begin
            if (reg_addr == CFG_BASE + ADDR_W'(4 * n)) begin
                reg_rdata = {29'd0, line_cfg[n]};
            end
        end
    end

endmodule

// File: rtl/isnc_line.sv
module isnc_line
    import isnc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_in,
    input  logic       line_en,
    input  logic [2:0] line_cfg,
    output logic       irq_out
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hist_q;
    logic                   cur;
    logic                   out_d;
    logic                   out_q;
    line_mode_e             mode;

    assign cur = sync_q[SYNC_STAGES-1];

    // Synchronizer and history: tracks the input regardless of mode, so a
    // mode change alone never looks like an edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
            hist_q <= cur;
        end
    end

    // Output forming per decoded mode
    always_comb begin
        mode = decode_sense(line_cfg);
        unique case (mode)
            MODE_HIGH: out_d = cur;
            MODE_LOW:  out_d = ~cur;
            MODE_UP:   out_d = cur & ~hist_q;
            MODE_DOWN: out_d = ~cur & hist_q;
            MODE_ANY:  out_d = cur ^ hist_q;
            default:   out_d = 1'b0;
        endcase
        if (!line_en) out_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign irq_out = out_q;

endmodule

// File: rtl/isnc_top.sv
module isnc_top
    import isnc_pkg::*;
#(
    parameter int NUM_LINES   = MAX_LINES,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    output logic [NUM_LINES-1:0] irq_out,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata
);

    logic [NUM_LINES-1:0]      line_en;
    logic [NUM_LINES-1:0][2:0] line_cfg;

    isnc_regs #(
        .NUM_LINES (NUM_LINES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .line_en   (line_en),
        .line_cfg  (line_cfg)
    );

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_conv
        isnc_line #(
            .SYNC_STAGES (SYNC_STAGES)
        ) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .raw_in   (irq_in[n]),
            .line_en  (line_en[n]),
            .line_cfg (line_cfg[n]),
            .irq_out  (irq_out[n])
        );
    end

endmodule

// File: rtl/isnc_chk.sv
module isnc_chk
    import isnc_pkg::*;
#(
    parameter int N = MAX_LINES
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N-1:0]        irq_out,
    input logic [N-1:0]        line_en,
    input logic [N-1:0][2:0]   line_cfg,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [31:0]         reg_rdata
);

    localparam int EW   = (N + 31) / 32;
    localparam int TAIL = N - 32 * (EW - 1);
    localparam logic [ADDR_W-1:0] CFG_END  = CFG_BASE + ADDR_W'(4 * N);
    localparam logic [ADDR_W-1:0] LAST_EN  = EN_BASE + ADDR_W'(4 * (EW - 1));

    logic [N-1:0] bad_m;
    logic [N-1:0] rise_m;
    logic [N-1:0] fall_m;

    always_comb begin
        for (int n = 0; n < N; n++) begin
            bad_m[n]  = (decode_sense(line_cfg[n]) == MODE_OFF);
            rise_m[n] = (line_cfg[n] == 3'b110);
            fall_m[n] = (line_cfg[n] == 3'b010);
        end
    end

    // R9: a line disabled at the previous edge is low now
    a_r9_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & ~$past(line_en)) == '0));

    // R10: undefined codes hold the output low
    a_r10_bad_code_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & $past(bad_m)) == '0));

    // R6 / R7: single-direction edge modes never pulse two cycles running
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_out & $past(irq_out) &
          (($past(rise_m) & $past(rise_m, 2)) | ($past(fall_m) & $past(fall_m, 2)))) == '0));

    // R3: configuration reads carry only the 3-bit code
    a_r3_cfg_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_addr >= CFG_BASE) && (reg_addr < CFG_END)) |-> (reg_rdata[31:3] == '0));

    // R2: bits beyond the last line in the last enable word read zero
    if (TAIL < 32) begin : g_tail
        a_r2_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_addr == LAST_EN) |-> (reg_rdata[31:TAIL] == '0));
    end

endmodule

bind isnc_top isnc_chk #(.N(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_out   (irq_out),
    .line_en   (line_en),
    .line_cfg  (line_cfg),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/sim_isnc_top.sv
`timescale 1ns/1ps
module sim_isnc_top;

    localparam int NL = 126;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   irq_in = '0;
    logic [NL-1:0]   irq_out;
    logic [11:0]     reg_addr = '0;
    logic            reg_wr = 1'b0;
    logic [31:0]     reg_wdata = '0;
    logic [31:0]     reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    isnc_top #(.NUM_LINES(NL)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .irq_out   (irq_out),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [127:0] outv();
        return {2'b00, irq_out};
    endfunction

    // Expected steady level for a code and a settled input value
    function automatic logic lvl(input logic [2:0] c, input logic v);
        if (c == 3'b100) return v;
        if (c == 3'b000) return ~v;
        return 1'b0;
    endfunction

    // Expected output on the cycle a transition to v arrives
    function automatic logic evt(input logic [2:0] c, input logic v);
        case (c)
            3'b100:  return v;
            3'b000:  return ~v;
            3'b110:  return v;
            3'b010:  return ~v;
            3'b111:  return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] c);
        case (c)
            3'b100:  return "R4";
            3'b000:  return "R5";
            3'b110:  return "R6";
            3'b010:  return "R7";
            3'b111:  return "R8";
            default: return "R10";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int lines [4] = '{0, 31, 32, 125};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: reset state
        check("R1 out", outv(), '0);
        for (int w = 0; w < 4; w++) begin
            rd(12'h010 + 12'(4 * w), v);
            check("R1 en", 128'(v), '0);
        end
        rd(12'h110, v);  check("R1 cfg0", 128'(v), '0);
        rd(12'h304, v);  check("R1 cfg125", 128'(v), '0);

        // R2: enable bank map and masking
        wr(12'h010, 32'hA5A5_5A5A);
        rd(12'h010, v);  check("R2 word0", 128'(v), 128'h0000_0000_0000_0000_0000_0000_A5A5_5A5A);
        rd(12'h014, v);  check("R2 word1 untouched", 128'(v), '0);
        wr(12'h01C, 32'hFFFF_FFFF);
        rd(12'h01C, v);  check("R2 tail", 128'(v), 128'h3FFF_FFFF);
        wr(12'h010, 32'h0);
        wr(12'h01C, 32'h0);

        // R3: configuration map
        wr(12'h124, 32'hFFFF_FFF6);
        rd(12'h124, v);  check("R3 code", 128'(v), 128'h6);
        wr(12'h308, 32'h7);
        rd(12'h308, v);  check("R3 index 126", 128'(v), '0);
        rd(12'h304, v);  check("R3 line125 kept", 128'(v), '0);
        wr(12'h00C, 32'hFFFF_FFFF);
        rd(12'h00C, v);  check("R3 unmapped", 128'(v), '0);

        // R4..R8, R10: sweep of every code on boundary lines
        foreach (lines[i]) begin
            for (int c = 0; c < 8; c++) begin
                int L = lines[i];
                logic [2:0] code = 3'(c);
                for (int w = 0; w < 4; w++) wr(12'h010 + 12'(4 * w), 32'h0);
                wr(12'h110 + 12'(4 * L), {29'd0, code});
                wr(12'h010 + 12'(4 * (L / 32)), 32'h1 << (L % 32));
                repeat (4) @(negedge clk);
                check({tag_of(code), " idle"}, outv(), 128'(lvl(code, 1'b0)) << L);
                irq_in[L] = 1'b1;
                repeat (3) @(posedge clk);
                @(negedge clk);
                check({tag_of(code), " up event"}, outv(), 128'(evt(code, 1'b1)) << L);
                @(negedge clk);
                check({tag_of(code), " up after"}, outv(), 128'(lvl(code, 1'b1)) << L);
                irq_in[L] = 1'b0;
                repeat (3) @(posedge clk);
                @(negedge clk);
                check({tag_of(code), " down event"}, outv(), 128'(evt(code, 1'b0)) << L);
                @(negedge clk);
                check({tag_of(code), " down after"}, outv(), 128'(lvl(code, 1'b0)) << L);
            end
        end

        // R12: all lines active-low, one input moves
        for (int n = 0; n < NL; n++) wr(12'h110 + 12'(4 * n), 32'h0);
        for (int w = 0; w < 4; w++) wr(12'h010 + 12'(4 * w), 32'hFFFF_FFFF);
        repeat (4) @(negedge clk);
        check("R12 all high", outv(), {2'b00, {NL{1'b1}}});
        irq_in[7] = 1'b1;
        repeat (4) @(negedge clk);
        check("R12 one line", outv(), {2'b00, {NL{1'b1}}} & ~(128'h1 << 7));

        // R9: read-modify-write disable of line 40
        rd(12'h014, v);
        wr(12'h014, v & ~(32'h1 << 8));
        rd(12'h014, v);  check("R2 rmw keeps others", 128'(v), 128'hFFFF_FEFF);
        repeat (2) @(negedge clk);
        check("R9 disabled low", outv(), {2'b00, {NL{1'b1}}} & ~(128'h1 << 7) & ~(128'h1 << 40));

        // R11: code changes on a steady-high input
        irq_in[3] = 1'b1;
        wr(12'h11C, 32'h4);
        repeat (4) @(negedge clk);
        check("R11 level high", 128'(irq_out[3]), 128'h1);
        wr(12'h11C, 32'h6);
        repeat (5) begin
            @(negedge clk);
            check("R11 to rise", 128'(irq_out[3]), '0);
        end
        wr(12'h11C, 32'h7);
        repeat (5) begin
            @(negedge clk);
            check("R11 to both", 128'(irq_out[3]), '0);
        end
        wr(12'h11C, 32'h2);
        repeat (5) begin
            @(negedge clk);
            check("R11 to fall", 128'(irq_out[3]), '0);
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule